// File: doc/BRIEF.md
# Master Clock Source Selector and Prescaler

This block produces the master clock of a chip as a one-cycle enable strobe, `mck_en`, on a single system clock. Three source strobes come in: a slow clock, a main clock and a PLL clock. Software picks one of them through a configuration register and sets a power-of-two divide ratio. The block then emits one master pulse for every N ticks of the chosen source. A second register restarts the PLL lock timer. The PLL reaches lock after a fixed number of slow-clock ticks.

A change of source or divide ratio never takes effect at once. The block first lets the old setting finish its current division period. It then applies the new setting and waits two ticks of the new source before it reports ready again. While the PLL is selected but not locked, the master clock runs from the main clock, and ready stays low until lock returns. A ready interrupt, with a set/clear enable, tells software when a change has completed. Reading the status register clears that interrupt.

The sequencing is done by a four-state machine:
- `ST_RUN`: the setting is in effect and ready is high.
- `ST_DRAIN`: the old period is finishing.
- `ST_SYNC`: the block is counting new-source ticks.
- `ST_RELOCK`: the PLL is selected and waiting for lock.

The transitions are:
- `ST_RUN` to `ST_DRAIN`: a changing configuration write.
- `ST_RUN` or `ST_SYNC` to `ST_RELOCK`: a PLL write while the PLL is in use.
- `ST_DRAIN` to `ST_SYNC` or `ST_RELOCK`: the last old-period pulse, the second choice when the new source is the unlocked PLL.
- `ST_SYNC` to `ST_RUN`: the second new-source tick.
- `ST_RELOCK` to `ST_SYNC`: lock seen.
- `ST_SYNC` or `ST_RELOCK` to `ST_DRAIN`: a further changing write.

Top module: `mclk_gen`

## Requirements
- R1: After reset, the configuration reads 0, status reads 0x01 (ready 1, lock 0, pending 0), `irq` is 0 and `mck_en` pulses on every slow tick.
- R2: Configuration bits [1:0] pick the source: 0 is the slow clock, 1 is the main clock, and 2 or 3 is the PLL clock. `mck_en` pulses only in cycles where the selected source ticks.
- R3: Configuration bits [4:2] hold code k, and the source is divided by 2^k for k = 0 to 6. Code 7 divides by 64.
- R4: A write to address 0 whose bits [4:0] differ from the last written value drops status bit 0 (ready) from the next cycle. A write of the same value leaves ready high and sets no interrupt.
- R5: After a changing write, the next `mck_en` pulse still comes at the old setting's spacing. The new setting is applied from that pulse on.
- R6: Ready returns high in the cycle after the second new-source tick that follows that boundary pulse.
- R7: A write to address 1 clears status bit 1 (lock) in the next cycle. Lock sets on the eighth slow tick after the write.
- R8: While the PLL is selected and unlocked, ready is low and `mck_en` follows the main clock at the programmed divide. Once lock returns, the PLL is used again and ready returns.
- R9: Ready going high sets status bit 2 (pending). `irq` is pending AND the enable bit. Bit 0 written as 1 sets the enable at address 3 and clears it at address 4. Address 5 bit 0 reads the enable.
- R10: A read strobe (`rd_en`) at address 2 clears the pending bit, unless a new ready event sets it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slow_tick | input | 1 | Slow clock enable strobe |
| main_tick | input | 1 | Main clock enable strobe |
| pll_tick | input | 1 | PLL clock enable strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_en | input | 1 | Register read strobe (side effects only) |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W | Combinational read data |
| mck_en | output | 1 | Master clock enable strobe |
| irq | output | 1 | Ready interrupt |

## Verification
A wrong state register shows up at once in status bit 0. It also shows up in the spacing of the next master pulse: a switch applied early gives a pulse gap that differs from the old period. A stuck sync or lock counter keeps ready or lock low past the exact tick the bench counts, so the fault shows within one source tick. A lost or misrouted fallback changes the master pulse spacing within one divide period after a PLL write.

// File: rtl/mclk_pkg.sv
package mclk_pkg;

    localparam int ADDR_W = 3;
    localparam int CSS_W  = 2;
    localparam int PRES_W = 3;
    localparam int CFG_W  = CSS_W + PRES_W;

    // register addresses
    localparam logic [ADDR_W-1:0] A_CFG   = 3'd0;
    localparam logic [ADDR_W-1:0] A_PLL   = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_IEN   = 3'd3;
    localparam logic [ADDR_W-1:0] A_IDIS  = 3'd4;
    localparam logic [ADDR_W-1:0] A_IMASK = 3'd5;

    typedef enum logic [1:0] {
        SRC_SLOW = 2'd0,
        SRC_MAIN = 2'd1,
        SRC_PLL  = 2'd2
    } src_t;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_SYNC   = 2'd2,
        ST_RELOCK = 2'd3
    } mst_t;

    typedef struct packed {
        logic [PRES_W-1:0] pres;
        logic [CSS_W-1:0]  css;
    } mcfg_t;

endpackage

// File: rtl/mclk_div.sv
module mclk_div #(
    parameter int MAX_CODE = 6,
    parameter int CODE_W   = 3,
    localparam int CNT_W   = (MAX_CODE < 1) ? 1 : MAX_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CODE_W-1:0] code,
    output logic              pulse
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    int unsigned      code_cl;

    // codes above the largest supported ratio clamp to it
    always_comb begin
        code_cl = (int'(code) > MAX_CODE) ? MAX_CODE : int'(code);
        limit   = CNT_W'((32'd1 << code_cl) - 32'd1);
    end

    assign pulse = tick && (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= pulse ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mclk_lock.sv
module mclk_lock #(
    parameter int LOCK_TICKS = 8,
    localparam int LCNT_W    = $clog2(LOCK_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic slow_tick,
    output logic locked
);

    logic [LCNT_W-1:0] cnt_q;
    logic              busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            locked <= 1'b0;
        end else if (restart) begin
            cnt_q  <= '0;
            busy_q <= 1'b1;
            locked <= 1'b0;
        end else if (busy_q && slow_tick) begin
            if (cnt_q == LCNT_W'(LOCK_TICKS - 1)) begin
                cnt_q  <= '0;
                busy_q <= 1'b0;
                locked <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mclk_irq.sv
module mclk_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic ready_set,
    input  logic en_set,
    input  logic en_clr,
    input  logic rd_clr,
    output logic pend,
    output logic int_en,
    output logic irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_en <= 1'b0;
            pend   <= 1'b0;
        end else begin
            if (en_set) begin
                int_en <= 1'b1;
            end else if (en_clr) begin
                int_en <= 1'b0;
            end
            if (ready_set) begin
                pend <= 1'b1;
            end else if (rd_clr) begin
                pend <= 1'b0;
            end
        end
    end

    assign irq = pend & int_en;

endmodule

// File: rtl/mclk_gen.sv
module mclk_gen
    import mclk_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int LOCK_TICKS = 8,
    parameter int SYNC_TICKS = 2,
    parameter int MAX_PRES   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              main_tick,
    input  logic              pll_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              mck_en,
    output logic              irq
);

    localparam int SYNC_W = (SYNC_TICKS < 2) ? 1 : $clog2(SYNC_TICKS);
    localparam logic [SYNC_W-1:0] SYNC_LAST = SYNC_W'(SYNC_TICKS - 1);

    mst_t              state_q, state_d;
    mcfg_t             nxt_cfg_q, act_cfg_q, wr_cfg, tgt_cfg;
    logic [SYNC_W-1:0] sync_q;
    logic              cfg_wr, cfg_chg, pll_wr;
    logic              act_pll, locked, eff_tick, div_pulse;
    logic              apply, sync_inc, ready, ready_rise;
    logic              irq_pend, int_en;
    src_t              eff_src;
    logic              unused_wr;

    assign unused_wr = ^wr_data[DATA_W-1:CFG_W];

    // register decode
    assign wr_cfg  = mcfg_t'(wr_data[CFG_W-1:0]);
    assign cfg_wr  = wr_en && (wr_addr == A_CFG);
    assign cfg_chg = cfg_wr && (wr_cfg != nxt_cfg_q);
    assign pll_wr  = wr_en && (wr_addr == A_PLL);
    assign tgt_cfg = cfg_wr ? wr_cfg : nxt_cfg_q;

    // effective source with fallback while the PLL is unlocked
    assign act_pll = act_cfg_q.css[1];
    always_comb begin
        if (act_pll) begin
            eff_src = locked ? SRC_PLL : SRC_MAIN;
        end else if (act_cfg_q.css[0]) begin
            eff_src = SRC_MAIN;
        end else begin
            eff_src = SRC_SLOW;
        end
        unique case (eff_src)
            SRC_SLOW: eff_tick = slow_tick;
            SRC_MAIN: eff_tick = main_tick;
            SRC_PLL:  eff_tick = pll_tick;
            default:  eff_tick = 1'b0;
        endcase
    end

    mclk_div #(
        .MAX_CODE (MAX_PRES),
        .CODE_W   (PRES_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (eff_tick),
        .code  (act_cfg_q.pres),
        .pulse (div_pulse)
    );

    mclk_lock #(
        .LOCK_TICKS (LOCK_TICKS)
    ) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (pll_wr),
        .slow_tick (slow_tick),
        .locked    (locked)
    );

    // next-state logic
    always_comb begin
        state_d  = state_q;
        apply    = 1'b0;
        sync_inc = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (cfg_chg) begin
                    state_d = ST_DRAIN;
                end else if (pll_wr && act_pll) begin
                    state_d = ST_RELOCK;
                end
            end
            ST_DRAIN: begin
                if (div_pulse) begin
                    apply = 1'b1;
                    if (tgt_cfg.css[1] && (!locked || pll_wr)) begin
                        state_d = ST_RELOCK;
                    end else begin
                        state_d = ST_SYNC;
                    end
                end
            end
            ST_SYNC: begin
                if (cfg_chg) begin
                    state_d = ST_DRAIN;
                end else if (pll_wr && act_pll) begin
                    state_d = ST_RELOCK;
                end else if (eff_tick) begin
                    if (sync_q == SYNC_LAST) begin
                        state_d = ST_RUN;
                    end else begin
                        sync_inc = 1'b1;
                    end
                end
            end
            ST_RELOCK: begin
                if (cfg_chg) begin
                    state_d = ST_DRAIN;
                end else if (locked && !pll_wr) begin
                    state_d = ST_SYNC;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // state register and configuration holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_RUN;
            nxt_cfg_q <= '0;
            act_cfg_q <= '0;
            sync_q    <= '0;
        end else begin
            state_q <= state_d;
            if (cfg_wr) begin
                nxt_cfg_q <= wr_cfg;
            end
            if (apply) begin
                act_cfg_q <= tgt_cfg;
            end
            if (state_q != ST_SYNC) begin
                sync_q <= '0;
            end else if (sync_inc) begin
                sync_q <= sync_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        ready      = (state_q == ST_RUN);
        ready_rise = (state_d == ST_RUN) && (state_q != ST_RUN);
        mck_en     = div_pulse;
        unique case (rd_addr)
            A_CFG:   rd_data = DATA_W'(nxt_cfg_q);
            A_STAT:  rd_data = DATA_W'({irq_pend, locked, ready});
            A_IMASK: rd_data = DATA_W'(int_en);
            default: rd_data = '0;
        endcase
    end

    mclk_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready_set (ready_rise),
        .en_set    (wr_en && (wr_addr == A_IEN) && wr_data[0]),
        .en_clr    (wr_en && (wr_addr == A_IDIS) && wr_data[0]),
        .rd_clr    (rd_en && (rd_addr == A_STAT)),
        .pend      (irq_pend),
        .int_en    (int_en),
        .irq       (irq)
    );

endmodule

// File: rtl/mclk_gen_chk.sv
module mclk_gen_chk
    import mclk_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CFG_W-1:0]  wr_cfg,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              slow_tick,
    input logic              main_tick,
    input logic              pll_tick,
    input logic              mck_en,
    input logic              irq,
    input logic              ready,
    input logic              locked,
    input logic [CFG_W-1:0]  nxt_cfg,
    input logic              act_pll,
    input logic              irq_pend,
    input logic              int_en
);

    // R2
    mck_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mck_en |-> (slow_tick || main_tick || pll_tick));

    // R4
    cfg_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CFG && wr_cfg != nxt_cfg) |=> !ready);

    // R6
    ready_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(slow_tick || main_tick || pll_tick));

    // R7
    lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_PLL) |=> !locked);

    // R8
    pll_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_pll && !locked) |-> !ready);

    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (int_en && irq_pend));

    // R10
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == A_STAT) |=> (!irq_pend || $rose(ready)));

endmodule

bind mclk_gen mclk_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_cfg    (wr_data[4:0]),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .slow_tick (slow_tick),
    .main_tick (main_tick),
    .pll_tick  (pll_tick),
    .mck_en    (mck_en),
    .irq       (irq),
    .ready     (ready),
    .locked    (locked),
    .nxt_cfg   (nxt_cfg_q),
    .act_pll   (act_pll),
    .irq_pend  (irq_pend),
    .int_en    (int_en)
);

// File: tb/mclk_gen_test.sv
module mclk_gen_test;
    import mclk_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_tick = 1'b0, main_tick = 1'b0, pll_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic       rd_en = 1'b0;
    logic [2:0] rd_addr = A_STAT;
    logic [7:0] rd_data;
    logic       mck_en, irq;

    int    cyc = 0, checks = 0, fails = 0;
    int    prev = 0, last_pulse = 0;
    bit    sb_restart = 1'b0;
    int    qi[$];
    string qr[$];

    mclk_gen uut (
        .clk(clk), .rst_n(rst_n),
        .slow_tick(slow_tick), .main_tick(main_tick), .pll_tick(pll_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .mck_en(mck_en), .irq(irq)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // source strobes: slow every 16, main every 3, PLL every 2 cycles
    always @(posedge clk) begin
        #1;
        slow_tick = (cyc % 16 == 5);
        main_tick = (cyc % 3 == 1);
        pll_tick  = (cyc % 2 == 0);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: pops expected pulse spacings
    always @(negedge clk) begin
        if (rst_n && mck_en) begin
            if (sb_restart) begin
                sb_restart = 1'b0;
                prev = cyc;
            end else if (qi.size() > 0) begin
                int    e;
                string r;
                e = qi.pop_front();
                r = qr.pop_front();
                chk(cyc - prev == e, r, cyc - prev, e);
                prev = cyc;
            end
            last_pulse = cyc;
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic write(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic read_clear();
        @(posedge clk); #1;
        rd_en = 1'b1; rd_addr = A_STAT;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
        rd_addr = A_STAT;
        #1;
    endtask

    task automatic expect_iv(input int iv, input int n, input string req);
        int t;
        sb_restart = 1'b1;
        for (int i = 0; i < n; i++) begin
            qi.push_back(iv);
            qr.push_back(req);
        end
        t = 0;
        while (qi.size() > 0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        if (qi.size() > 0) begin
            chk(1'b0, req, qi.size(), 0);
            qi.delete();
            qr.delete();
            sb_restart = 1'b0;
        end
    endtask

    function automatic logic tick_of(input int src);
        return (src == 0) ? slow_tick : (src == 1) ? main_tick : pll_tick;
    endfunction

    // changing write: checks ready drop, old-period boundary and ready timing
    task automatic switch_chk(input logic [7:0] d, input int old_iv, input int src);
        int w, t, n;
        write(A_CFG, d);
        w = last_pulse;
        chk(rd_data[0] == 1'b0, "R4 ready drop", rd_data[0], 0);
        t = 0;
        do begin
            @(negedge clk);
            t++;
        end while (!mck_en && t < 1000);
        chk(cyc - w == old_iv, "R5 boundary spacing", cyc - w, old_iv);
        n = 0;
        while (n < 2 && t < 2000) begin
            @(negedge clk);
            t++;
            if (tick_of(src)) n++;
        end
        chk(rd_data[0] == 1'b0, "R6 ready low at 2nd tick", rd_data[0], 0);
        @(negedge clk);
        chk(rd_data[0] == 1'b1, "R6 ready after 2nd tick", rd_data[0], 1);
    endtask

    initial begin
        logic [7:0] v;
        bit bad;
        int n;

        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rd_data == 8'h01, "R1 status", rd_data, 1);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        peek(A_CFG, v);
        chk(v == 8'h00, "R1 cfg", v, 0);
        peek(A_IMASK, v);
        chk(v == 8'h00, "R9 mask reset", v, 0);
        expect_iv(16, 3, "R1 slow cadence");

        // R9 enable set
        write(A_IEN, 8'h01);
        peek(A_IMASK, v);
        chk(v[0] == 1'b1, "R9 enable set", v[0], 1);

        // to main /16 (0x11)
        switch_chk(8'h11, 16, 1);
        chk(irq == 1'b1, "R9 irq on ready", irq, 1);
        expect_iv(48, 3, "R2 R3 main div16");

        // R10 status read clears pending
        read_clear();
        chk(rd_data[2] == 1'b0, "R10 pending cleared", rd_data[2], 0);
        chk(irq == 1'b0, "R10 irq cleared", irq, 0);

        // R4 unchanged write
        write(A_CFG, 8'h11);
        bad = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (rd_data[0] != 1'b1 || irq != 1'b0) bad = 1'b1;
        end
        chk(!bad, "R4 same value no effect", bad, 0);

        // R9 disable, then back to slow /1
        write(A_IDIS, 8'h01);
        peek(A_IMASK, v);
        chk(v[0] == 1'b0, "R9 enable clear", v[0], 0);
        switch_chk(8'h00, 48, 0);
        chk(irq == 1'b0, "R9 masked irq", irq, 0);
        chk(rd_data[2] == 1'b1, "R9 pending set", rd_data[2], 1);
        read_clear();
        chk(rd_data[2] == 1'b0, "R10 pending cleared", rd_data[2], 0);
        expect_iv(16, 2, "R2 slow div1");

        // R7 PLL lock timing
        write(A_PLL, 8'h5A);
        chk(rd_data[1] == 1'b0, "R7 lock cleared", rd_data[1], 0);
        n = 0;
        while (n < 8) begin
            @(negedge clk);
            if (slow_tick) n++;
        end
        chk(rd_data[1] == 1'b0, "R7 lock low at 8th tick", rd_data[1], 0);
        @(negedge clk);
        chk(rd_data[1] == 1'b1, "R7 lock after 8th tick", rd_data[1], 1);

        // PLL /4 (0x0B)
        switch_chk(8'h0B, 16, 2);
        expect_iv(8, 3, "R2 R3 pll div4");

        // R8 reprogram PLL while selected
        write(A_PLL, 8'h33);
        chk(rd_data[0] == 1'b0, "R8 ready low", rd_data[0], 0);
        chk(rd_data[1] == 1'b0, "R7 lock cleared", rd_data[1], 0);
        expect_iv(12, 3, "R8 fallback main div4");
        n = 0;
        while (rd_data[0] != 1'b1 && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(rd_data[0] == 1'b1, "R8 ready after lock", rd_data[0], 1);
        chk(rd_data[1] == 1'b1, "R8 lock back", rd_data[1], 1);
        expect_iv(8, 2, "R8 pll restored");

        // R3 code 7 clamps to 64, on main (0x1D)
        switch_chk(8'h1D, 8, 1);
        expect_iv(192, 2, "R3 code7 div64");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule